// File: doc/BRIEF.md
# SCL Bit-Rate Clock Generator

This block derives the serial-clock timing for a two-wire bus master from the chip clock. The chip clock first passes through a programmable prescaler, which yields a module-clock tick once every (prescale + 1) chip cycles. The module ticks are then counted through two phases, SCL low and SCL high. Each phase lasts its own programmed count plus a fixed extra delay of 7, 6 or 5 ticks, and the prescale setting selects which. The prescale value is meant to keep the module clock at roughly 7 to 12 MHz. Software picks it so that the module clock runs slower rather than faster when the input clock does not divide evenly.

A run-enable bit holds the block in reset while it is clear. In reset, every counter is zero and SCL is reported released, with the low-phase indicator deasserted. On release the low phase is counted first. A one-cycle bit strobe marks the last chip cycle of every high phase. The three divider values are copied into shadow registers while the block is held in reset and again at each period boundary. A change on the inputs therefore never disturbs a period that is already running.

Top module: `scl_rate_gen`

## Requirements
- R1: While `run_en` is 0 (or `rst_n` is 0), `mod_tick`, `scl_low` and `bit_strobe` are all 0 from the next clock edge onward.
- R2: While running, `mod_tick` is a one-cycle pulse every (P+1) clock cycles, where P is the latched prescale value. The first pulse falls in the (P+1)-th cycle after the release edge.
- R3: The extra per-phase delay d is 7 ticks when P = 0, 6 ticks when P = 1 and 5 ticks when P >= 2.
- R4: `scl_low` becomes 1 at the first clock edge that samples `run_en` = 1 and stays 1 for exactly (L + d)(P+1) cycles, during which exactly L + d module ticks occur. L is the low count.
- R5: The high phase (`scl_low` = 0) that follows lasts exactly (H + d)(P+1) cycles, where H is the high count. The next low phase starts right after it.
- R6: `bit_strobe` is high for exactly one cycle per period: the last cycle of the high phase, coinciding with a `mod_tick` pulse.
- R7: Prescale, low and high values are sampled in the last cycle before release and again at each period end. A change made while a period runs affects only the following period.
- R8: Clearing `run_en` in either phase aborts the period at the next edge, returning the outputs to the R1 state. A later release starts a fresh low phase using the values present just before that release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chip clock |
| rst_n | input | 1 | Synchronous active-low chip reset |
| run_en | input | 1 | Block run enable; 0 holds the block in reset |
| prescale | input | 16 | Prescaler value P (module clock = clk / (P+1)) |
| low_count | input | 16 | Programmed SCL-low count L in module ticks |
| high_count | input | 16 | Programmed SCL-high count H in module ticks |
| mod_tick | output | 1 | One-cycle module-clock tick |
| scl_low | output | 1 | 1 while SCL is in its low phase, 0 in high phase and in reset |
| bit_strobe | output | 1 | One-cycle pulse at the end of each high phase |

## Verification
A prescaler counter that skips or repeats a value shows up in the very first period. It moves the first `mod_tick` and stretches both phase lengths by a whole multiple of the tick interval. A wrong extra-delay selection or an off-by-one in the phase compare changes the measured low run, so it is visible one phase after release. A shadow register that reloads too early lengthens or shortens the period in which an input changed, rather than the next one. An aborted period that leaves a counter non-zero makes the following low run come out short.

// File: rtl/scl_rate_pkg.sv
package scl_rate_pkg;

  // extra module-clock ticks appended to each SCL phase, selected by prescale
  function automatic logic [3:0] extra_delay(input logic [31:0] psc);
    if (psc == 32'd0)      return 4'd7;
    else if (psc == 32'd1) return 4'd6;
    else                   return 4'd5;
  endfunction

  // total ticks of one phase: programmed count plus the extra delay
  function automatic logic [31:0] phase_len(input logic [31:0] cnt,
                                            input logic [3:0]  d);
    return cnt + 32'(d);
  endfunction

endpackage

// File: rtl/scl_cfg_shadow.sv
module scl_cfg_shadow #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_en,
  input  logic          reload,
  input  logic [DW-1:0] psc_in,
  input  logic [DW-1:0] low_in,
  input  logic [DW-1:0] high_in,
  output logic [DW-1:0] psc_q,
  output logic [DW-1:0] low_q,
  output logic [DW-1:0] high_q
);

  logic take;
  assign take = !run_en || reload;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      psc_q  <= '0;
      low_q  <= '0;
      high_q <= '0;
    end else if (take) begin
      psc_q  <= psc_in;
      low_q  <= low_in;
      high_q <= high_in;
    end
  end

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !reload) |=> ($stable(psc_q) && $stable(low_q) && $stable(high_q))); // R7

endmodule

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_en,
  input  logic          active,
  input  logic [DW-1:0] psc_q,
  output logic          tick
);

  logic [DW-1:0] pre_cnt;
  logic          at_top;

  assign at_top = (pre_cnt == psc_q);
  assign tick   = active && at_top;

  always_ff @(posedge clk) begin
    if (!rst_n || !run_en || !active) begin
      pre_cnt <= '0;
    end else if (at_top) begin
      pre_cnt <= '0;
    end else begin
      pre_cnt <= pre_cnt + 1'b1;
    end
  end

  AST_PRE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (pre_cnt <= psc_q)); // R2

  AST_PRE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (pre_cnt == '0)); // R1

endmodule

// File: rtl/scl_phase_timer.sv
module scl_phase_timer
  import scl_rate_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_en,
  input  logic          tick,
  input  logic [DW-1:0] psc_q,
  input  logic [DW-1:0] low_q,
  input  logic [DW-1:0] high_q,
  output logic          active,
  output logic          scl_low,
  output logic          bit_strobe
);

  localparam int CW = DW + 1;

  logic [3:0]    d_sel;
  logic [CW-1:0] low_len;
  logic [CW-1:0] high_len;
  logic [CW-1:0] cur_len;
  logic [CW-1:0] phase_cnt;
  logic          last_tick;
  logic          phase_end;

  assign d_sel     = extra_delay(32'(psc_q));
  assign low_len   = CW'(phase_len(32'(low_q), d_sel));
  assign high_len  = CW'(phase_len(32'(high_q), d_sel));
  assign cur_len   = scl_low ? low_len : high_len;
  assign last_tick = (phase_cnt == cur_len - 1'b1);
  assign phase_end = tick && last_tick;
  assign bit_strobe = active && !scl_low && phase_end;

  always_ff @(posedge clk) begin
    if (!rst_n || !run_en) begin
      active    <= 1'b0;
      scl_low   <= 1'b0;
      phase_cnt <= '0;
    end else if (!active) begin
      active    <= 1'b1;
      scl_low   <= 1'b1;
      phase_cnt <= '0;
    end else if (tick) begin
      if (last_tick) begin
        phase_cnt <= '0;
        scl_low   <= !scl_low;
      end else begin
        phase_cnt <= phase_cnt + 1'b1;
      end
    end
  end

  AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (phase_cnt < cur_len)); // R4

  AST_LOW_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> scl_low); // R4

  AST_STROBE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    bit_strobe |-> (tick && !scl_low)); // R6

  AST_STROBE_TO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_strobe && run_en) |=> (scl_low && !bit_strobe)); // R6

  AST_EXTRA_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (psc_q == '0) |-> (low_len == CW'(low_q) + CW'(7))); // R3

endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_en,
  input  logic [DW-1:0] prescale,
  input  logic [DW-1:0] low_count,
  input  logic [DW-1:0] high_count,
  output logic          mod_tick,
  output logic          scl_low,
  output logic          bit_strobe
);

  logic [DW-1:0] psc_q;
  logic [DW-1:0] low_q;
  logic [DW-1:0] high_q;
  logic          active;
  logic          tick;
  logic          strobe;
  logic          low_ph;

  scl_cfg_shadow #(.DW(DW)) u_shadow (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_en  (run_en),
    .reload  (strobe),
    .psc_in  (prescale),
    .low_in  (low_count),
    .high_in (high_count),
    .psc_q   (psc_q),
    .low_q   (low_q),
    .high_q  (high_q)
  );

  scl_prescaler #(.DW(DW)) u_presc (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_en (run_en),
    .active (active),
    .psc_q  (psc_q),
    .tick   (tick)
  );

  scl_phase_timer #(.DW(DW)) u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_en     (run_en),
    .tick       (tick),
    .psc_q      (psc_q),
    .low_q      (low_q),
    .high_q     (high_q),
    .active     (active),
    .scl_low    (low_ph),
    .bit_strobe (strobe)
  );

  assign mod_tick   = tick;
  assign scl_low    = low_ph;
  assign bit_strobe = strobe;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (!scl_low && !mod_tick && !bit_strobe)); // R1

endmodule

// File: tb/test_scl_rate_gen.sv
module test_scl_rate_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_en = 1'b0;
  logic [15:0] prescale = '0;
  logic [15:0] low_count = '0;
  logic [15:0] high_count = '0;
  logic        mod_tick, scl_low, bit_strobe;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = !clk;

  scl_rate_gen #(.DW(16)) i_scl_rate_gen (
    .clk(clk), .rst_n(rst_n), .run_en(run_en),
    .prescale(prescale), .low_count(low_count), .high_count(high_count),
    .mod_tick(mod_tick), .scl_low(scl_low), .bit_strobe(bit_strobe)
  );

  // {prescale, low, high, expected extra delay}
  localparam logic [55:0] VEC [6] = '{
    {16'd0, 16'd1,  16'd1, 8'd7},
    {16'd1, 16'd3,  16'd2, 8'd6},
    {16'd2, 16'd0,  16'd4, 8'd5},
    {16'd4, 16'd2,  16'd0, 8'd5},
    {16'd3, 16'd10, 16'd6, 8'd5},
    {16'd0, 16'd0,  16'd0, 8'd7}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle_quiet(input string req);
    chk(req, {29'd0, mod_tick, scl_low, bit_strobe}, 0);
  endtask

  // caller has already stepped to the first sample of a low phase
  task automatic measure(output int lo, output int hi, output int lo_ticks,
                         output int first_tick, output int strobes,
                         output int strobe_idx, output int strobe_no_tick);
    lo = 0; hi = 0; lo_ticks = 0; first_tick = -1;
    strobes = 0; strobe_idx = -1; strobe_no_tick = 0;
    while (scl_low && lo < 100000) begin
      lo++;
      if (mod_tick) begin
        lo_ticks++;
        if (first_tick < 0) first_tick = lo;
      end
      @(negedge clk);
    end
    while (!scl_low && hi < 100000) begin
      hi++;
      if (bit_strobe) begin
        strobes++;
        strobe_idx = hi;
        if (!mod_tick) strobe_no_tick++;
      end
      @(negedge clk);
    end
  endtask

  task automatic load(input int p, input int l, input int h);
    prescale = 16'(p); low_count = 16'(l); high_count = 16'(h);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog (R4): actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int lo, hi, lt, ft, sc, si, snt;
    int p, l, h, d;

    // R1: chip reset, then held by run_en
    repeat (3) @(negedge clk);
    idle_quiet("R1 chip reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    idle_quiet("R1 run_en low");

    // table walk: R2 R3 R4 R5 R6
    foreach (VEC[i]) begin
      p = int'(VEC[i][55:40]); l = int'(VEC[i][39:24]);
      h = int'(VEC[i][23:8]);  d = int'(VEC[i][7:0]);
      run_en = 1'b0;
      load(p, l, h);
      @(negedge clk);
      idle_quiet("R1 between cases");
      run_en = 1'b1;
      @(negedge clk);
      measure(lo, hi, lt, ft, sc, si, snt);
      chk("R2 first tick", ft, p + 1);
      chk("R3 ticks in low phase", lt, l + d);
      chk("R4 low length", lo, (l + d) * (p + 1));
      chk("R5 high length", hi, (h + d) * (p + 1));
      chk("R6 strobe count", sc, 1);
      chk("R6 strobe at end", si, hi);
      chk("R6 strobe with tick", snt, 0);
      measure(lo, hi, lt, ft, sc, si, snt);
      chk("R5 second period low", lo, (l + d) * (p + 1));
      chk("R2 second period tick spacing", ft, p + 1);
    end

    // R7: inputs changed mid-period apply from the next period
    run_en = 1'b0;
    load(0, 1, 1);
    @(negedge clk);
    run_en = 1'b1;
    @(negedge clk);
    load(1, 5, 3);
    measure(lo, hi, lt, ft, sc, si, snt);
    chk("R7 current low unchanged", lo, 8);
    chk("R7 current high unchanged", hi, 8);
    measure(lo, hi, lt, ft, sc, si, snt);
    chk("R7 next low uses new values", lo, (5 + 6) * 2);
    chk("R7 next high uses new values", hi, (3 + 6) * 2);

    // R8: abort during low, re-release with fresh values
    run_en = 1'b0;
    load(1, 3, 2);
    @(negedge clk);
    run_en = 1'b1;
    repeat (5) @(negedge clk);
    run_en = 1'b0;
    @(negedge clk);
    idle_quiet("R8 abort in low");
    load(0, 2, 1);
    @(negedge clk);
    run_en = 1'b1;
    @(negedge clk);
    measure(lo, hi, lt, ft, sc, si, snt);
    chk("R8 fresh low after abort", lo, 9);
    chk("R8 fresh high after abort", hi, 8);
    chk("R8 first tick after abort", ft, 1);

    // R8: abort during high phase
    while (scl_low) @(negedge clk);
    run_en = 1'b0;
    @(negedge clk);
    idle_quiet("R8 abort in high");
    @(negedge clk);
    idle_quiet("R8 stays quiet");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule